// File: doc/BRIEF.md
# Tree-Structured Scan Read-Out Collector

This block collects the read-out of an array of addressable scan cells and brings the content of the one cell that is being read to a single output bit. Each cell offers two signals, a data bit and a control bit. The control bit says that the cell owns the read-out path during this read. The array is split into groups of four. A four-input collecting stage picks one bit from each group and passes it upward together with its own control bit. The stages form a tree of `LEVELS` levels, so one output serves `4**LEVELS` cells.

Address decoding happens outside the block. In normal use exactly one cell raises its control bit. If more than one does, the tree still produces a defined result and raises a conflict flag that travels with that result. When `PIPE` is 1, every stage registers its outputs. A read then reaches the output `LEVELS` cycles later, and a new read can start on every cycle. When `PIPE` is 0, the whole tree is combinational.

Top module: `sco_tree`

## Requirements
- R1: With exactly one control bit set, `out_dat` equals the data bit of that cell. Cell i is bit i of `cell_dat` and `cell_ctl`.
- R2: `out_ctl` is 1 exactly when at least one bit of `cell_ctl` was set for the read being reported.
- R3: When several control bits are set, `out_dat` carries the data bit of the lowest-numbered active cell. This holds whether the active cells share a group of four or sit in different groups.
- R4: `out_conf` is 1 exactly when two or more control bits were set for the read being reported. It is never 1 while `out_ctl` is 0.
- R5: With no control bit set, `out_dat`, `out_ctl` and `out_conf` are all 0, whatever the data inputs hold.
- R6: A read applied to the inputs appears at the outputs exactly `PIPE*LEVELS` clock cycles later. Reads applied on consecutive cycles come out on consecutive cycles, in order.
- R7: A synchronous active-high `rst` clears every stage register, so all three outputs read 0 after a reset edge. This includes any read that was still in flight.
- R8: Cells are grouped in fours by index, and groups are grouped in fours by group index, up to `LEVELS` levels. The tree covers `4**LEVELS` cells, and every cell from the first to the last is reachable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the stage registers |
| rst | input | 1 | Synchronous active-high reset |
| cell_dat | input | 4**LEVELS | Read-out data bit of each cell, cell i on bit i |
| cell_ctl | input | 4**LEVELS | Ownership bit of each cell, cell i on bit i |
| out_dat | output | 1 | Data bit of the winning cell, or 0 when no cell is active |
| out_ctl | output | 1 | Some cell owned the read-out path |
| out_conf | output | 1 | More than one cell claimed the read-out path |

## Verification
The hardest cases to reach are the ones where the conflict comes from different places in the tree. In one, two active cells share a leaf group, so the leaf stage detects the conflict. In the other, the active cells sit in different leaf groups, so only the upper stage sees two active children, and both the conflict flag and the lowest-index choice must survive one more stage. The stimulus table contains both arrangements, and each is given data values that tell the winner apart from the loser. The table is streamed one read per cycle, so a wrong stage count or a flag that falls out of step with its data shows up as a mismatch against a read in a neighbouring slot.

// File: rtl/sco_pkg.sv
package sco_pkg;
  localparam int FANIN = 4;

  function automatic logic many_set(input logic [FANIN-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < FANIN; i++) n += int'(v[i]);
    return n > 1;
  endfunction
endpackage

// File: rtl/sco_prio_pick.sv
module sco_prio_pick
  import sco_pkg::*;
(
  input  logic [FANIN-1:0] req,
  input  logic [FANIN-1:0] dat,
  output logic             pick,
  output logic             any,
  output logic             multi
);
  always_comb begin
    pick = 1'b0;
    for (int i = FANIN - 1; i >= 0; i--) begin
      if (req[i]) pick = dat[i];
    end
    any   = |req;
    multi = many_set(req);
  end
endmodule

// File: rtl/sco_stage.sv
module sco_stage #(
  parameter int W    = 3,
  parameter int PIPE = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (PIPE != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end

    AST_STAGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (q == '0)) else $error("stage not cleared"); // R7
  end else begin : g_wire
    assign q = d;
  end
endmodule

// File: rtl/sco_macrocell.sv
module sco_macrocell
  import sco_pkg::*;
#(
  parameter int PIPE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FANIN-1:0] in_dat,
  input  logic [FANIN-1:0] in_ctl,
  input  logic [FANIN-1:0] in_conf,
  output logic             up_dat,
  output logic             up_ctl,
  output logic             up_conf
);
  logic pick, any, multi;
  logic [2:0] nxt, cur;

  sco_prio_pick u_pick (
    .req  (in_ctl),
    .dat  (in_dat),
    .pick (pick),
    .any  (any),
    .multi(multi)
  );

  // a conflict below travels with the data it accompanies
  assign nxt = {multi | (|in_conf), any, pick & any};

  sco_stage #(.W(3), .PIPE(PIPE)) u_stage (
    .clk(clk),
    .rst(rst),
    .d  (nxt),
    .q  (cur)
  );

  assign up_conf = cur[2];
  assign up_ctl  = cur[1];
  assign up_dat  = cur[0];

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !up_ctl |-> (!up_dat && !up_conf)) else $error("idle output not zero"); // R5

  AST_CONF_NEEDS_CTL: assert property (@(posedge clk) disable iff (rst)
    up_conf |-> up_ctl) else $error("conflict without owner"); // R4

  if (PIPE != 0) begin : g_chk
    AST_PRIO_LOW: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_ctl[0])) |-> (up_dat == $past(in_dat[0])))
      else $error("lowest input did not win"); // R3

    AST_CTL_OR: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (up_ctl == ($past(in_ctl) != '0)))
      else $error("control not merged"); // R2
  end
endmodule

// File: rtl/sco_tree.sv
module sco_tree
  import sco_pkg::*;
#(
  parameter int LEVELS = 2,
  parameter int PIPE   = 1,
  localparam int NCELL = FANIN ** LEVELS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCELL-1:0] cell_dat,
  input  logic [NCELL-1:0] cell_ctl,
  output logic             out_dat,
  output logic             out_ctl,
  output logic             out_conf
);
  for (genvar l = 0; l < LEVELS; l++) begin : lvl
    localparam int NODES = FANIN ** (LEVELS - 1 - l);
    logic [NODES-1:0] d, c, f;

    for (genvar j = 0; j < NODES; j++) begin : node
      logic [FANIN-1:0] id, ic, icf;
      if (l == 0) begin : g_leaf
        assign id  = cell_dat[FANIN*j +: FANIN];
        assign ic  = cell_ctl[FANIN*j +: FANIN];
        assign icf = '0;
      end else begin : g_inner
        assign id  = lvl[l-1].d[FANIN*j +: FANIN];
        assign ic  = lvl[l-1].c[FANIN*j +: FANIN];
        assign icf = lvl[l-1].f[FANIN*j +: FANIN];
      end

      sco_macrocell #(.PIPE(PIPE)) u_mc (
        .clk    (clk),
        .rst    (rst),
        .in_dat (id),
        .in_ctl (ic),
        .in_conf(icf),
        .up_dat (d[j]),
        .up_ctl (c[j]),
        .up_conf(f[j])
      );
    end
  end

  assign out_dat  = lvl[LEVELS-1].d[0];
  assign out_ctl  = lvl[LEVELS-1].c[0];
  assign out_conf = lvl[LEVELS-1].f[0];

  if (PIPE != 0) begin : g_top_chk
    AST_TOP_RESET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_dat && !out_ctl && !out_conf))
      else $error("outputs not cleared"); // R7
  end
endmodule

// File: tb/sco_tree_test.sv
`timescale 1ns/1ps
module sco_tree_test;
  localparam int LEVELS = 2;
  localparam int PIPE   = 1;
  localparam int NCELL  = 16;
  localparam int LAT    = PIPE * LEVELS;
  localparam int NVEC   = 14;

  // {ctl, dat, exp_ctl, exp_dat, exp_conf}
  localparam logic [34:0] VEC [NVEC] = '{
    {16'h0000, 16'hFFFF, 3'b000},
    {16'h0001, 16'h0001, 3'b110},
    {16'h0001, 16'hFFFE, 3'b100},
    {16'h8000, 16'h8000, 3'b110},
    {16'h8000, 16'h7FFF, 3'b100},
    {16'h0030, 16'h0020, 3'b101},
    {16'h0030, 16'h0010, 3'b111},
    {16'h0110, 16'h0100, 3'b101},
    {16'h0110, 16'h0010, 3'b111},
    {16'h0400, 16'h0400, 3'b110},
    {16'h0020, 16'hFFDF, 3'b100},
    {16'hFFFF, 16'h0000, 3'b101},
    {16'hFFFF, 16'h0001, 3'b111},
    {16'h0000, 16'h0000, 3'b000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCELL-1:0] cell_dat = '0;
  logic [NCELL-1:0] cell_ctl = '0;
  logic out_dat, out_ctl, out_conf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sco_tree #(.LEVELS(LEVELS), .PIPE(PIPE)) uut (
    .clk(clk), .rst(rst), .cell_dat(cell_dat), .cell_ctl(cell_ctl),
    .out_dat(out_dat), .out_ctl(out_ctl), .out_conf(out_conf)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ctl/dat/conf actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    // R7: reset holds outputs at zero even with every cell active
    cell_ctl = '1; cell_dat = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset", {out_ctl, out_dat, out_conf}, 3'b000);
    cell_ctl = '0; cell_dat = '0;
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 R8: stream one read per cycle, check LAT cycles later
    for (int i = 0; i < NVEC + LAT; i++) begin
      @(negedge clk);
      if (i >= LAT)
        check($sformatf("R1/R2/R3/R4/R5/R6/R8 vec %0d", i - LAT),
              {out_ctl, out_dat, out_conf}, VEC[i-LAT][2:0]);
      if (i < NVEC) begin
        cell_ctl = VEC[i][34:19];
        cell_dat = VEC[i][18:3];
      end else begin
        cell_ctl = '0; cell_dat = '0;
      end
    end

    // R6: exact latency of a single read, output quiet one cycle early
    @(negedge clk);
    cell_ctl = 16'h0200; cell_dat = 16'h0200;
    @(negedge clk);
    cell_ctl = '0; cell_dat = '0;
    check("R6 early", {out_ctl, out_dat, out_conf}, 3'b000);
    @(negedge clk);
    check("R6 on time", {out_ctl, out_dat, out_conf}, 3'b110);
    @(negedge clk);
    check("R6 single pulse", {out_ctl, out_dat, out_conf}, 3'b000);

    // R7: a read in flight is flushed by reset
    cell_ctl = 16'h0003; cell_dat = 16'h0001;
    @(negedge clk);
    cell_ctl = '0; cell_dat = '0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 flush", {out_ctl, out_dat, out_conf}, 3'b000);
    @(negedge clk);
    check("R7 flush later", {out_ctl, out_dat, out_conf}, 3'b000);

    // R5: data toggling with no owner never reaches the output
    cell_dat = 16'hA5A5;
    @(negedge clk);
    cell_dat = 16'h5A5A;
    @(negedge clk);
    @(negedge clk);
    check("R5 no owner", {out_ctl, out_dat, out_conf}, 3'b000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule